// File: doc/BRIEF.md
# Stretchable Bus Cycle Controller

This block sits between an 8-bit processor core with a multiplexed, two-phase bus and the memory system behind it. It runs from a master clock and splits every bus cycle into an address phase and a data phase. While the address phase runs, the core's data lines carry the bank byte. The block captures that byte and joins it with the 16-bit offset to form a 24-bit address.

When the address phase ends, the block decodes the full address. The decode picks one of two external buses, each with its own read and write strobes. It drives RAM and ROM selects and decides whether the data phase must be lengthened for a slow region. A one-clock ready pulse closes each cycle so the core can move on.

A single configuration input makes the upper half of the bank space fast.

Top module: `bus_cycle_ctl`

## Requirements
- R1: A fast cycle lasts 6 master clocks: 3 in the address phase (cycle clocks 0..2) and 3 in the data phase (cycle clocks 3..5).
- R2: A cycle lasts 8 master clocks, because its data phase is lengthened by 2, when the bank is 0x40..0x7F, or when the bank has bit 6 clear and the offset is 0x8000..0xFFFF. The exception is banks 0x80..0xFF while `fast_hi_en` is 1: these are always fast.
- R3: `ext_addr` = {bank, offset} is captured on the edge that ends the address phase. The bank is taken from `core_data` and the offset from `core_addr`. `ext_addr` then holds through the next cycle's address phase, whatever the core inputs do.
- R4: An address with bank 0x00..0x3F and offset 0x2100..0x21FF uses the B-bus strobes, and the A-bus strobes stay low. All other addresses use the A-bus strobes. `b_addr` shows the low offset byte of the captured address.
- R5: No strobe is high during cycle clocks 0..2. Exactly one strobe is high from cycle clock 3 through the next-to-last clock of the cycle. All strobes are low on the last clock.
- R6: `core_rw` = 1 gives the read strobe and `core_rw` = 0 gives the write strobe of the chosen bus. `core_rw` is sampled with the address.
- R7: `rom_sel` is 1 for offsets 0x8000..0xFFFF in banks with bit 6 clear, for every offset in banks 0x40..0x7D, and for every offset in banks 0xC0..0xFF. It is 0 otherwise.
- R8: `ram_sel` is 1 for banks 0x7E..0x7F, and for offsets 0x0000..0x1FFF in banks with bit 6 clear. It is 0 otherwise.
- R9: `cyc_ready` is high for exactly the last master clock of each cycle.
- R10: Reset puts the controller at cycle clock 0 with all strobes, selects, `cyc_ready` and `ext_addr` at 0. After reset is released, the first fast cycle raises `cyc_ready` on the 5th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_hi_en | input | 1 | 1 makes banks 0x80..0xFF fast |
| core_addr | input | 16 | Offset from the core |
| core_data | input | 8 | Multiplexed lines; they carry the bank during the address phase |
| core_rw | input | 1 | 1 read, 0 write |
| ext_addr | output | 24 | Captured {bank, offset} |
| a_rd | output | 1 | A-bus read strobe |
| a_wr | output | 1 | A-bus write strobe |
| b_rd | output | 1 | B-bus read strobe |
| b_wr | output | 1 | B-bus write strobe |
| b_addr | output | 8 | B-bus register address (low offset byte) |
| ram_sel | output | 1 | RAM select |
| rom_sel | output | 1 | ROM select |
| cyc_ready | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench builds the block with its default parameters: phases of 3 and 3 clocks, 2 extra slow clocks, and B-bus page 0x21. With these values every cycle is short enough to run all 256 banks against eight boundary offsets (0x0000, 0x1FFF, 0x2000, 0x2100, 0x21FF, 0x7FFF, 0x8000, 0xFFFF), both directions, and both settings of the fast-bank input. That brings every decode boundary within reach, along with both cycle lengths and every strobe window. The core inputs are scrambled during each data phase, which shows that the captured address does not follow them.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int BANK_W = 8;
  localparam int OFS_W  = 16;
  localparam int FULL_W = BANK_W + OFS_W;

  typedef struct packed {
    logic bbus;
    logic slow;
    logic rom;
    logic ram;
  } bcc_dec_t;
endpackage

// File: rtl/bcc_phase_seq.sv
module bcc_phase_seq #(
  parameter int PH1_CLKS   = 3,
  parameter int PH2_CLKS   = 3,
  parameter int SLOW_EXTRA = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_next,
  output logic end_ph1,
  output logic pre_last
);
  localparam int CYC_MAX   = PH1_CLKS + PH2_CLKS + SLOW_EXTRA;
  localparam int CNT_W     = $clog2(CYC_MAX);
  localparam int LAST_FAST = PH1_CLKS + PH2_CLKS - 1;
  localparam int LAST_SLOW = CYC_MAX - 1;

  logic [CNT_W-1:0] cnt;
  logic             slow_q;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign last     = slow_q ? CNT_W'(LAST_SLOW) : CNT_W'(LAST_FAST);
  assign end_ph1  = (cnt == CNT_W'(PH1_CLKS - 1));
  assign pre_last = (cnt == last - CNT_W'(1));
  assign at_last  = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt <= at_last ? '0 : cnt + CNT_W'(1);
      if (end_ph1) slow_q <= slow_next;
    end
  end
endmodule

// File: rtl/bcc_addr_decode.sv
module bcc_addr_decode
  import bcc_pkg::*;
#(
  parameter logic [7:0] B_PAGE   = 8'h21,
  parameter int         LRAM_MSB = 3
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              fast_hi_en,
  output bcc_dec_t          dec
);
  logic lo_half;
  logic upper_ofs;
  logic wram_bank;
  logic mid_banks;

  assign lo_half   = !bank[6];
  assign upper_ofs = ofs[OFS_W-1];
  assign wram_bank = (bank[BANK_W-1:1] == 7'b0111111);
  assign mid_banks = (bank[7:6] == 2'b01);

  always_comb begin
    dec.bbus = (bank[7:6] == 2'b00) && (ofs[OFS_W-1:OFS_W-8] == B_PAGE);
    dec.slow = (lo_half && upper_ofs) || mid_banks;
    if (fast_hi_en && bank[7]) dec.slow = 1'b0;
    dec.rom  = (lo_half && upper_ofs) || (mid_banks && !wram_bank) ||
               (bank[7:6] == 2'b11);
    dec.ram  = wram_bank ||
               (lo_half && (ofs[OFS_W-1:OFS_W-LRAM_MSB] == '0));
  end
endmodule

// File: rtl/bcc_strobe_gen.sv
module bcc_strobe_gen
  import bcc_pkg::*;
#(
  parameter int NUM_BUS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_ph1,
  input  logic              pre_last,
  input  bcc_dec_t          dec,
  input  logic              core_rw,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  output logic [FULL_W-1:0] ext_addr,
  output logic [NUM_BUS-1:0] rd_stb,
  output logic [NUM_BUS-1:0] wr_stb,
  output logic [7:0]        b_addr,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic              cyc_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr  <= '0;
      b_addr    <= '0;
      ram_sel   <= 1'b0;
      rom_sel   <= 1'b0;
      cyc_ready <= 1'b0;
    end else begin
      cyc_ready <= pre_last;
      if (end_ph1) begin
        ext_addr <= {bank, ofs};
        b_addr   <= ofs[7:0];
        ram_sel  <= dec.ram;
        rom_sel  <= dec.rom;
      end
    end
  end

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    logic hit;
    assign hit = (g == 1) ? dec.bbus : !dec.bbus;
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_stb[g] <= 1'b0;
        wr_stb[g] <= 1'b0;
      end else if (end_ph1) begin
        rd_stb[g] <= hit && core_rw;
        wr_stb[g] <= hit && !core_rw;
      end else if (pre_last) begin
        rd_stb[g] <= 1'b0;
        wr_stb[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
  import bcc_pkg::*;
#(
  parameter int         PH1_CLKS   = 3,
  parameter int         PH2_CLKS   = 3,
  parameter int         SLOW_EXTRA = 2,
  parameter logic [7:0] B_PAGE     = 8'h21
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fast_hi_en,
  input  logic [15:0] core_addr,
  input  logic [7:0]  core_data,
  input  logic        core_rw,
  output logic [23:0] ext_addr,
  output logic        a_rd,
  output logic        a_wr,
  output logic        b_rd,
  output logic        b_wr,
  output logic [7:0]  b_addr,
  output logic        ram_sel,
  output logic        rom_sel,
  output logic        cyc_ready
);
  localparam int NUM_BUS = 2;

  bcc_dec_t           dec;
  logic               end_ph1;
  logic               pre_last;
  logic [NUM_BUS-1:0] rd_stb;
  logic [NUM_BUS-1:0] wr_stb;

  bcc_addr_decode #(.B_PAGE(B_PAGE)) u_dec (
    .bank       (core_data),
    .ofs        (core_addr),
    .fast_hi_en (fast_hi_en),
    .dec        (dec)
  );

  bcc_phase_seq #(
    .PH1_CLKS   (PH1_CLKS),
    .PH2_CLKS   (PH2_CLKS),
    .SLOW_EXTRA (SLOW_EXTRA)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .slow_next (dec.slow),
    .end_ph1   (end_ph1),
    .pre_last  (pre_last)
  );

  bcc_strobe_gen #(.NUM_BUS(NUM_BUS)) u_stb (
    .clk       (clk),
    .rst       (rst),
    .end_ph1   (end_ph1),
    .pre_last  (pre_last),
    .dec       (dec),
    .core_rw   (core_rw),
    .bank      (core_data),
    .ofs       (core_addr),
    .ext_addr  (ext_addr),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .b_addr    (b_addr),
    .ram_sel   (ram_sel),
    .rom_sel   (rom_sel),
    .cyc_ready (cyc_ready)
  );

  assign a_rd = rd_stb[0];
  assign a_wr = wr_stb[0];
  assign b_rd = rd_stb[1];
  assign b_wr = wr_stb[1];
endmodule

// File: rtl/bcc_chk.sv
module bcc_chk (
  input logic        clk,
  input logic        rst,
  input logic        a_rd,
  input logic        a_wr,
  input logic        b_rd,
  input logic        b_wr,
  input logic        ram_sel,
  input logic        rom_sel,
  input logic        cyc_ready,
  input logic [23:0] ext_addr
);
  logic any_stb;
  assign any_stb = a_rd | a_wr | b_rd | b_wr;

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_rd, a_wr, b_rd, b_wr}));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_ready |=> !cyc_ready);

  // R5
  quiet_at_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_ready |-> !any_stb);

  // R5
  strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(any_stb) |-> cyc_ready);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ext_addr) |-> (any_stb && !$past(any_stb)));

  // R8
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ram_sel && rom_sel));

  // R4
  bbus_page_chk: assert property (@(posedge clk) disable iff (rst)
    (b_rd || b_wr) |-> (ext_addr[15:8] == 8'h21 && ext_addr[23:22] == 2'b00));
endmodule

bind bus_cycle_ctl bcc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_rd      (a_rd),
  .a_wr      (a_wr),
  .b_rd      (b_rd),
  .b_wr      (b_wr),
  .ram_sel   (ram_sel),
  .rom_sel   (rom_sel),
  .cyc_ready (cyc_ready),
  .ext_addr  (ext_addr)
);

// File: tb/tb_bus_cycle_ctl.sv
module tb_bus_cycle_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_hi_en = 1'b0;
  logic [15:0] core_addr = '0;
  logic [7:0]  core_data = '0;
  logic        core_rw = 1'b1;
  logic [23:0] ext_addr;
  logic        a_rd, a_wr, b_rd, b_wr;
  logic [7:0]  b_addr;
  logic        ram_sel, rom_sel, cyc_ready;

  int checks = 0;
  int failures = 0;
  logic [23:0] prev_addr = '0;

  always #5 clk = ~clk;

  bus_cycle_ctl dut (
    .clk(clk), .rst(rst), .fast_hi_en(fast_hi_en),
    .core_addr(core_addr), .core_data(core_data), .core_rw(core_rw),
    .ext_addr(ext_addr), .a_rd(a_rd), .a_wr(a_wr), .b_rd(b_rd), .b_wr(b_wr),
    .b_addr(b_addr), .ram_sel(ram_sel), .rom_sel(rom_sel), .cyc_ready(cyc_ready)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ofs_of(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h1FFF;
      2: return 16'h2000;
      3: return 16'h2100;
      4: return 16'h21FF;
      5: return 16'h7FFF;
      6: return 16'h8000;
      default: return 16'hFFFF;
    endcase
  endfunction

  // Starts at a negedge where cyc_ready was just seen high; ends at the next one.
  task automatic run_cycle(input logic [7:0] bk, input logic [15:0] of,
                           input logic rw, input logic fh);
    logic lo_banks, slow, rom, ram, bbus;
    logic [3:0] exp_stb, stb, stb4;
    logic rom4, ram4;
    logic [7:0] baddr4;
    int len_exp, len;
    bit early, bad_win, bad_hold, bad_addr, stb_at_end;
    lo_banks = (bk < 8'h40) || (bk >= 8'h80 && bk < 8'hC0);
    slow = lo_banks ? (of >= 16'h8000) : (bk >= 8'h40 && bk < 8'h80);
    if (fh && bk >= 8'h80) slow = 1'b0;
    rom  = (lo_banks && of >= 16'h8000) || (bk >= 8'h40 && bk <= 8'h7D) || (bk >= 8'hC0);
    ram  = (bk == 8'h7E) || (bk == 8'h7F) || (lo_banks && of < 16'h2000);
    bbus = (bk < 8'h40) && (of >= 16'h2100) && (of <= 16'h21FF);
    len_exp = slow ? 8 : 6;
    exp_stb = bbus ? (rw ? 4'b0010 : 4'b0001) : (rw ? 4'b1000 : 4'b0100);
    core_data = bk; core_addr = of; core_rw = rw; fast_hi_en = fh;
    len = 0; early = 0; bad_win = 0; bad_hold = 0; bad_addr = 0; stb_at_end = 0;
    stb4 = '0; rom4 = 0; ram4 = 0; baddr4 = '0;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      stb = {a_rd, a_wr, b_rd, b_wr};
      if (cyc_ready) begin
        len = j;
        stb_at_end = (stb != 4'b0);
        if (ext_addr != {bk, of}) bad_addr = 1;
        break;
      end
      if (j <= 3) begin
        if (stb != 4'b0) early = 1;
        if (j == 3 && ext_addr != prev_addr) bad_hold = 1;
      end else begin
        if (stb != exp_stb) bad_win = 1;
        if (ext_addr != {bk, of}) bad_addr = 1;
        if (j == 4) begin
          stb4 = stb; rom4 = rom_sel; ram4 = ram_sel; baddr4 = b_addr;
          core_data = ~bk; core_addr = ~of; core_rw = ~rw;
        end
      end
    end
    chk(len == len_exp, slow ? "R2 R9 slow cycle length" : "R1 R9 fast cycle length",
        32'(len), 32'(len_exp));
    chk(!early, "R5 strobe before clock 3", 32'(early), 0);
    chk(!bad_win && !stb_at_end, "R5 strobe window", {bad_win, stb_at_end}, 0);
    chk(stb4 == exp_stb, bbus ? "R4 R6 bus strobe" : "R6 bus strobe", 32'(stb4), 32'(exp_stb));
    chk(!bad_hold && !bad_addr, "R3 address capture and hold", {bad_hold, bad_addr}, 0);
    chk(baddr4 == of[7:0], "R4 b_addr low byte", 32'(baddr4), 32'(of[7:0]));
    chk(rom4 == rom, "R7 rom_sel", 32'(rom4), 32'(rom));
    chk(ram4 == ram, "R8 ram_sel", 32'(ram4), 32'(ram));
    prev_addr = {bk, of};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk({a_rd, a_wr, b_rd, b_wr, ram_sel, rom_sel, cyc_ready} == 7'b0,
        "R10 outputs in reset", {a_rd, a_wr, b_rd, b_wr, ram_sel, rom_sel, cyc_ready}, 0);
    chk(ext_addr == 24'h0, "R10 ext_addr in reset", 32'(ext_addr), 0);
    rst = 1'b0;
    n = 0;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (cyc_ready) begin n = j; break; end
    end
    chk(n == 5, "R10 first ready after reset", 32'(n), 5);
    prev_addr = 24'h0;
    for (int b = 0; b < 256; b++)
      for (int oi = 0; oi < 8; oi++)
        for (int rw = 0; rw < 2; rw++)
          for (int fh = 0; fh < 2; fh++)
            run_cycle(8'(b), ofs_of(oi), rw[0], fh[0]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule